// File: doc/BRIEF.md
# LED Driver Stream Controller

This block sequences a bank of serial LED driver chips. All chips share one shift clock, one display (grayscale) clock and one latch line, and each chip has its own serial data line. Software-side logic picks one of four operations: writing a configuration word, clocking the configuration back out for debug, an open-LED detection pass, or continuous streaming of pixel bit-planes from an upstream frame source.

Streaming is organised in segments of 512 display-clock cycles. Each segment starts with 72 blank cycles. Nine bit-planes of 48 bits follow, and a one-cycle pause separates each plane from the next. Each latch command is coded as the number of consecutive shift-clock edges with the latch line high. The upstream source receives a ready flag one slot ahead of every bit it must supply, so no bit is ever dropped.

The controller runs from a double-rate clock. One internal phase advances the control logic. A second phase, delayed by a quarter of the output period, forms the shift and display clocks, so data and latch change well away from both clock edges.

Top module: `led_stream_ctrl`

## Requirements
- R1: While reset is asserted, sclkOut, gclkOut, latOut, sdata, pixReady and sliceOut are all 0.
- R2: When idle, the controller produces no clocks and no latch. A pulse on modeGo starts the operation chosen by modeSel (0 configuration write, 1 configuration dump, 2 open-LED detection, 3 stream). After a stream start, the clocks stay off until sliceStart is seen, and the segment's slot 0 begins one slot after that.
- R3: sliceOut repeats the value sliceStart had at the previous slot boundary, in every mode.
- R4: Within a stream segment, gclkOut pulses in every one of the 512 slots.
- R5: Slots 0 to 71 of a segment carry no sclk pulse, no latch and all-zero data.
- R6: After the first 72 slots, the segment holds nine 48-slot data words. Words 0 to 7 are each followed by one pause slot with no sclk pulse. After any slot with latOut high, the next slot either still has the latch high or has no sclk pulse.
- R7: pixReady is high exactly in the slot before each data slot, which gives 432 per segment. The pixData value present at that slot boundary appears on sdata in the data slot. In every slot without an sclk pulse, sdata is 0.
- R8: latOut is high only together with an sclk pulse. It is high for the last 3 data slots of words 0 to 7 (write-grayscale latch) and for the last 5 data slots of word 8, which ends on slot 511 (final latch).
- R9: A modeSel change during a segment does not cut it short. The full segment completes, and the controller returns to idle after slot 511 if modeSel is no longer 3.
- R10: A configuration write shifts the 48-bit cfgWord MSB first, with the same bit on every sdata line. latOut is high for the last 11 bits, one pause slot follows, and the controller returns to idle.
- R11: A configuration dump gives 48 sclk slots with latOut low and sdata 0, then one pause slot, then idle.
- R12: Open-LED detection gives one sclk slot with latOut high (buffer latch), one pause slot, then 4 gclk-only slots, then idle.
- R13: At every control update edge, sclkOut and gclkOut are low. Clock pulses begin a quarter output period after the data and latch change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Double-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Operation select: 0 write config, 1 dump, 2 open-LED detect, 3 stream |
| modeGo | input | 1 | Start pulse, taken only while idle |
| sliceStart | input | 1 | New-slice pulse from the frame source |
| cfgWord | input | 48 | Configuration word sent to all drivers |
| pixData | input | 30 | One pixel bit per driver lane |
| pixReady | output | 1 | Frame source must present the next bit at the coming slot boundary |
| sliceOut | output | 1 | Slice pulse re-timed for the column multiplexer |
| sclkOut | output | 1 | Shared shift clock |
| gclkOut | output | 1 | Shared display clock |
| latOut | output | 1 | Shared latch line, width-coded commands |
| sdata | output | 30 | Serial data, one line per driver |

## Verification
A wrong slot counter or word counter shows up within one slot as a misplaced sclk pulse, latch or ready flag. The bench compares all of these every slot against a position-based reference, so the error is caught in the slot where the fault first appears. A ready flag that is one slot late makes the bench present filler data in a data slot, and the sdata comparison catches it at once. A sequence that runs too long or ends too early is found at the first slot where the controller should be idle.

// File: rtl/led_stream_pkg.sv
package led_stream_pkg;

  typedef enum logic [1:0] {
    MODE_CFG    = 2'd0,
    MODE_DUMP   = 2'd1,
    MODE_LOD    = 2'd2,
    MODE_STREAM = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_SEQ
  } ctrlStateT;

  // Per-slot strobes from control to datapath
  typedef struct packed {
    logic sclkOn;
    logic gclkOn;
    logic latOn;
    logic srcPix;
    logic srcCfg;
    logic cfgLoad;
    logic cfgShift;
  } strobeT;

endpackage

// File: rtl/led_stream_clkgen.sv
module led_stream_clkgen (
  input  logic clkFast,
  input  logic rstN,
  input  logic sclkGate,
  input  logic gclkGate,
  output logic stepEn,
  output logic sclkOut,
  output logic gclkOut
);

  logic phA;
  logic phB;

  // Control phase: half rate of clkFast
  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) phA <= 1'b0;
    else       phA <= ~phA;
  end

  // Output phase: same rate, delayed by half a fast cycle (quarter output period)
  always_ff @(negedge clkFast or negedge rstN) begin
    if (!rstN) phB <= 1'b0;
    else       phB <= phA;
  end

  assign stepEn  = ~phA;
  assign sclkOut = phB & sclkGate;
  assign gclkOut = phB & gclkGate;

endmodule

// File: rtl/led_stream_fsm.sv
module led_stream_fsm
  import led_stream_pkg::*;
#(
  parameter int CHANNELS = 48,
  parameter int GS_BITS  = 9,
  parameter int SEG_LOG  = 9,
  parameter int CFG_BITS = 48,
  parameter int LAT_BUF  = 1,
  parameter int LAT_WRT  = 3,
  parameter int LAT_FIN  = 5,
  parameter int LAT_CFG  = 11,
  parameter int LOD_GCLK = 4
) (
  input  logic       clkFast,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic [1:0] modeSel,
  input  logic       modeGo,
  input  logic       sliceStart,
  output strobeT     strb,
  output logic       pixReady
);

  localparam int SEG_LEN = 1 << SEG_LOG;
  localparam int LEAD    = SEG_LEN - GS_BITS * CHANNELS - (GS_BITS - 1);
  localparam int BIT_W   = $clog2(CHANNELS + 1);
  localparam int WORD_W  = $clog2(GS_BITS + 1);
  localparam int SEQ_MAX = CFG_BITS + LAT_BUF + LOD_GCLK + 2;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

  ctrlStateT         stateQ;
  modeT              modeQ;
  logic [SEG_LOG-1:0] posQ;
  logic [BIT_W-1:0]  bitQ;
  logic [WORD_W-1:0] wordQ;
  logic [SEQ_W-1:0]  idxQ;

  logic inLead, lastWord, runData, runLat;
  int   latSpan;
  int   seqN, seqW, seqG, idxI;

  // Stream slot decode
  always_comb begin
    inLead   = posQ < SEG_LOG'(LEAD);
    lastWord = wordQ == WORD_W'(GS_BITS - 1);
    latSpan  = lastWord ? LAT_FIN : LAT_WRT;
    runData  = !inLead && (bitQ < BIT_W'(CHANNELS));
    runLat   = runData && (int'(bitQ) >= CHANNELS - latSpan);
  end

  // Short-sequence shape per mode: shift length, latch width, gclk tail
  always_comb begin
    idxI = int'(idxQ);
    case (modeQ)
      MODE_CFG:  begin seqN = CFG_BITS; seqW = LAT_CFG; seqG = 0;        end
      MODE_DUMP: begin seqN = CFG_BITS; seqW = 0;       seqG = 0;        end
      default:   begin seqN = LAT_BUF;  seqW = LAT_BUF; seqG = LOD_GCLK; end
    endcase
  end

  always_comb begin
    strb = '0;
    case (stateQ)
      ST_IDLE: strb.cfgLoad = modeGo;
      ST_RUN: begin
        strb.sclkOn = runData;
        strb.gclkOn = 1'b1;
        strb.latOn  = runLat;
        strb.srcPix = runData;
      end
      ST_SEQ: begin
        if (idxI < seqN) begin
          strb.sclkOn   = 1'b1;
          strb.latOn    = idxI >= seqN - seqW;
          strb.srcCfg   = modeQ == MODE_CFG;
          strb.cfgShift = modeQ == MODE_CFG;
        end else if (idxI > seqN) begin
          strb.gclkOn = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign pixReady = (stateQ == ST_RUN) && runData;

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      modeQ  <= MODE_CFG;
      posQ   <= '0;
      bitQ   <= '0;
      wordQ  <= '0;
      idxQ   <= '0;
    end else if (stepEn) begin
      case (stateQ)
        ST_IDLE: begin
          if (modeGo) begin
            modeQ  <= modeT'(modeSel);
            idxQ   <= '0;
            stateQ <= (modeSel == MODE_STREAM) ? ST_WAIT : ST_SEQ;
          end
        end
        ST_WAIT: begin
          if (sliceStart) begin
            stateQ <= ST_RUN;
            posQ   <= '0;
            bitQ   <= '0;
            wordQ  <= '0;
          end
        end
        ST_RUN: begin
          if (posQ == SEG_LOG'(SEG_LEN - 1)) begin
            posQ  <= '0;
            bitQ  <= '0;
            wordQ <= '0;
            if (modeSel != MODE_STREAM) stateQ <= ST_IDLE;
          end else begin
            posQ <= posQ + 1'b1;
            if (!inLead) begin
              if (bitQ == BIT_W'(CHANNELS)) begin
                bitQ  <= '0;
                wordQ <= wordQ + 1'b1;
              end else begin
                bitQ <= bitQ + 1'b1;
              end
            end
          end
        end
        ST_SEQ: begin
          if (idxI == seqN + seqG) stateQ <= ST_IDLE;
          else                     idxQ   <= idxQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/led_stream_dpath.sv
module led_stream_dpath
  import led_stream_pkg::*;
#(
  parameter int NUM_DRV  = 30,
  parameter int CFG_BITS = 48
) (
  input  logic                clkFast,
  input  logic                rstN,
  input  logic                stepEn,
  input  strobeT              strb,
  input  logic [NUM_DRV-1:0]  pixData,
  input  logic [CFG_BITS-1:0] cfgWord,
  input  logic                sliceStart,
  output logic                sclkGate,
  output logic                gclkGate,
  output logic                latOut,
  output logic                sliceOut,
  output logic [NUM_DRV-1:0]  sdata
);

  logic [CFG_BITS-1:0] cfgSh;

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      sclkGate <= 1'b0;
      gclkGate <= 1'b0;
      latOut   <= 1'b0;
      sliceOut <= 1'b0;
      cfgSh    <= '0;
    end else if (stepEn) begin
      sclkGate <= strb.sclkOn;
      gclkGate <= strb.gclkOn;
      latOut   <= strb.latOn;
      sliceOut <= sliceStart;
      if (strb.cfgLoad)       cfgSh <= cfgWord;
      else if (strb.cfgShift) cfgSh <= {cfgSh[CFG_BITS-2:0], 1'b0};
    end
  end

  // One output register per driver lane
  for (genvar lane = 0; lane < NUM_DRV; lane++) begin : gLane
    always_ff @(posedge clkFast or negedge rstN) begin
      if (!rstN)       sdata[lane] <= 1'b0;
      else if (stepEn) sdata[lane] <= strb.srcPix ? pixData[lane]
                                    : (strb.srcCfg & cfgSh[CFG_BITS-1]);
    end
  end

endmodule

// File: rtl/led_stream_ctrl.sv
module led_stream_ctrl
  import led_stream_pkg::*;
#(
  parameter int NUM_DRV  = 30,
  parameter int CHANNELS = 48,
  parameter int GS_BITS  = 9,
  parameter int SEG_LOG  = 9,
  parameter int CFG_BITS = 48,
  parameter int LAT_BUF  = 1,
  parameter int LAT_WRT  = 3,
  parameter int LAT_FIN  = 5,
  parameter int LAT_CFG  = 11,
  parameter int LOD_GCLK = 4
) (
  input  logic                clkFast,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                modeGo,
  input  logic                sliceStart,
  input  logic [CFG_BITS-1:0] cfgWord,
  input  logic [NUM_DRV-1:0]  pixData,
  output logic                pixReady,
  output logic                sliceOut,
  output logic                sclkOut,
  output logic                gclkOut,
  output logic                latOut,
  output logic [NUM_DRV-1:0]  sdata
);

  strobeT strb;
  logic   stepEn;
  logic   sclkGate;
  logic   gclkGate;

  led_stream_clkgen uClk (
    .clkFast (clkFast),
    .rstN    (rstN),
    .sclkGate(sclkGate),
    .gclkGate(gclkGate),
    .stepEn  (stepEn),
    .sclkOut (sclkOut),
    .gclkOut (gclkOut)
  );

  led_stream_fsm #(
    .CHANNELS(CHANNELS), .GS_BITS(GS_BITS), .SEG_LOG(SEG_LOG),
    .CFG_BITS(CFG_BITS), .LAT_BUF(LAT_BUF), .LAT_WRT(LAT_WRT),
    .LAT_FIN(LAT_FIN), .LAT_CFG(LAT_CFG), .LOD_GCLK(LOD_GCLK)
  ) uFsm (
    .clkFast   (clkFast),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .modeSel   (modeSel),
    .modeGo    (modeGo),
    .sliceStart(sliceStart),
    .strb      (strb),
    .pixReady  (pixReady)
  );

  led_stream_dpath #(.NUM_DRV(NUM_DRV), .CFG_BITS(CFG_BITS)) uDp (
    .clkFast   (clkFast),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .strb      (strb),
    .pixData   (pixData),
    .cfgWord   (cfgWord),
    .sliceStart(sliceStart),
    .sclkGate  (sclkGate),
    .gclkGate  (gclkGate),
    .latOut    (latOut),
    .sliceOut  (sliceOut),
    .sdata     (sdata)
  );

endmodule

// File: rtl/led_stream_ctrl_chk.sv
module led_stream_ctrl_chk #(
  parameter int NUM_DRV = 30
) (
  input logic               clkFast,
  input logic               rstN,
  input logic               stepEn,
  input logic               sclkGate,
  input logic               latOut,
  input logic               sclkOut,
  input logic               pixReady,
  input logic               sliceStart,
  input logic               sliceOut,
  input logic [NUM_DRV-1:0] sdata
);

  // R8: a latch level is only ever presented with a shift edge
  p_lat_with_shift_r8: assert property (@(posedge clkFast) disable iff (!rstN)
    latOut |-> sclkGate);

  // R7: a ready slot is always followed by a shifting slot
  p_ready_leads_data_r7: assert property (@(posedge clkFast) disable iff (!rstN)
    (stepEn && pixReady) |=> sclkGate);

  // R7: data lines rest at zero whenever nothing is shifted
  p_quiet_data_r7: assert property (@(posedge clkFast) disable iff (!rstN)
    !sclkGate |-> (sdata == '0));

  // R13: shift clock is low at every control update edge
  p_shift_low_at_update_r13: assert property (@(posedge clkFast) disable iff (!rstN)
    stepEn |-> !sclkOut);

  // R6: the slot after a latch run carries no shift edge
  p_pause_after_latch_r6: assert property (@(posedge clkFast) disable iff (!rstN)
    (stepEn && latOut) |=> (latOut || !sclkGate));

  // R3: slice pulse is echoed one slot later
  p_slice_echo_r3: assert property (@(posedge clkFast) disable iff (!rstN)
    stepEn |=> (sliceOut == $past(sliceStart)));

endmodule

bind led_stream_ctrl led_stream_ctrl_chk #(.NUM_DRV(NUM_DRV)) uChk (
  .clkFast   (clkFast),
  .rstN      (rstN),
  .stepEn    (stepEn),
  .sclkGate  (sclkGate),
  .latOut    (latOut),
  .sclkOut   (sclkOut),
  .pixReady  (pixReady),
  .sliceStart(sliceStart),
  .sliceOut  (sliceOut),
  .sdata     (sdata)
);

// File: tb/led_stream_ctrl_test.sv
module led_stream_ctrl_test;

  localparam int NUM_DRV  = 30;
  localparam int CFG_BITS = 48;
  localparam int LEAD     = 72;
  localparam int WORD     = 48;
  localparam int LAST     = 511;

  logic                clkFast = 1'b0;
  logic                rstN = 1'b0;
  logic [1:0]          modeSel = 2'd0;
  logic                modeGo = 1'b0;
  logic                sliceStart = 1'b0;
  logic [CFG_BITS-1:0] cfgWord = '0;
  logic [NUM_DRV-1:0]  pixData = '0;
  logic                pixReady, sliceOut, sclkOut, gclkOut, latOut;
  logic [NUM_DRV-1:0]  sdata;

  always #10 clkFast = ~clkFast;   // 50 MHz

  led_stream_ctrl uut (
    .clkFast(clkFast), .rstN(rstN), .modeSel(modeSel), .modeGo(modeGo),
    .sliceStart(sliceStart), .cfgWord(cfgWord), .pixData(pixData),
    .pixReady(pixReady), .sliceOut(sliceOut), .sclkOut(sclkOut),
    .gclkOut(gclkOut), .latOut(latOut), .sdata(sdata)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model state: 0 idle, 1 wait, 2 run, 3 short sequence
  int mSt = 0, mPos = 0, mIdx = 0, mMode = 0;
  logic [CFG_BITS-1:0] mCfg = '0;
  int itemCnt = 0;
  int readyCount = 0;
  bit lastReady = 0;

  always @(posedge clkFast) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit isData(int p);
    return p >= LEAD && ((p - LEAD) % (WORD + 1)) != WORD;
  endfunction

  function automatic bit latExp(int p);
    int w, b;
    if (!isData(p)) return 0;
    w = (p - LEAD) / (WORD + 1);
    b = (p - LEAD) % (WORD + 1);
    return (w == 8) ? (b >= WORD - 5) : (b >= WORD - 3);
  endfunction

  function automatic logic [NUM_DRV-1:0] pattern(int k);
    logic [31:0] v;
    v = (k * 32'h9E3779B1) ^ (k << 11) ^ 32'h1357_2468;
    return v[NUM_DRV-1:0];
  endfunction

  task automatic runSlot();
    logic expS, expG, expL, expR;
    logic [NUM_DRV-1:0] expD;
    string tag;
    int n, w, g;
    expS = 0; expG = 0; expL = 0; expD = '0; tag = "R2";
    case (mSt)
      0: begin
        if (modeGo) begin
          mMode = modeSel; mIdx = 0; mCfg = cfgWord;
          mSt = (modeSel == 2'd3) ? 1 : 3;
        end
      end
      1: begin
        if (sliceStart) begin mSt = 2; mPos = 0; end
      end
      2: begin
        expG = 1; expS = isData(mPos); expL = latExp(mPos);
        expD = expS ? pixData : '0;
        if (modeSel != 2'd3)      tag = "R9";
        else if (mPos < LEAD)     tag = "R5";
        else if (!expS)           tag = "R6";
        else if (expL)            tag = "R8";
        else                      tag = "R7";
        if (mPos == LAST) begin
          mPos = 0;
          if (modeSel != 2'd3) mSt = 0;
        end else mPos++;
      end
      default: begin
        n = (mMode == 2) ? 1 : CFG_BITS;
        w = (mMode == 0) ? 11 : ((mMode == 1) ? 0 : 1);
        g = (mMode == 2) ? 4 : 0;
        tag = (mMode == 0) ? "R10" : ((mMode == 1) ? "R11" : "R12");
        if (mIdx < n) begin
          expS = 1; expL = (mIdx >= n - w);
          if (mMode == 0) expD = {NUM_DRV{mCfg[n-1-mIdx]}};
        end else if (mIdx > n) expG = 1;
        if (mIdx == n + g) mSt = 0; else mIdx++;
      end
    endcase
    expR = (mSt == 2) && isData(mPos);

    @(posedge clkFast);
    #3;
    chk("R13", "sclk before quarter", sclkOut, 0);
    chk("R13", "gclk before quarter", gclkOut, 0);
    #10;
    chk(tag, "sclk", sclkOut, expS);
    chk((mSt == 2 || expG) ? "R4" : tag, "gclk", gclkOut, expG);
    chk(tag, "lat", latOut, expL);
    chk(tag, "sdata", sdata, expD);
    chk(tag, "pixReady", pixReady, expR);
    chk("R3", "sliceOut", sliceOut, sliceStart);
    lastReady = pixReady;
    if (pixReady) readyCount++;
    @(posedge clkFast);
    #2;
  endtask

  task automatic step(int count);
    for (int i = 0; i < count; i++) begin
      if (lastReady) begin pixData = pattern(itemCnt); itemCnt++; end
      else pixData = '1;   // filler that must never reach sdata
      runSlot();
    end
  endtask

  initial begin
    #25;
    chk("R1", "sclk in reset", sclkOut, 0);
    chk("R1", "gclk in reset", gclkOut, 0);
    chk("R1", "lat in reset", latOut, 0);
    chk("R1", "sdata in reset", sdata, 0);
    chk("R1", "pixReady in reset", pixReady, 0);
    chk("R1", "sliceOut in reset", sliceOut, 0);
    #20 rstN = 1'b1;            // t=45, next posedge is an update edge

    step(3);                    // idle, nothing requested (R2)

    cfgWord = 48'hB4E1_93C7_5A0F;  // R10 configuration write
    modeSel = 2'd0; modeGo = 1'b1; step(1); modeGo = 1'b0;
    step(CFG_BITS + 4);

    modeSel = 2'd1; modeGo = 1'b1; step(1); modeGo = 1'b0;   // R11 dump
    step(CFG_BITS + 4);

    modeSel = 2'd2; modeGo = 1'b1; step(1); modeGo = 1'b0;   // R12 open-LED pass
    step(10);

    modeSel = 2'd3; modeGo = 1'b1; step(1); modeGo = 1'b0;   // R2 wait for slice
    step(5);
    readyCount = 0;
    sliceStart = 1'b1; step(1); sliceStart = 1'b0;
    step(512);                  // segment 1
    sliceStart = 1'b1; step(1); sliceStart = 1'b0;   // slot 0 of segment 2, echo R3
    step(200);
    modeSel = 2'd0;             // R9 request to leave mid-segment
    step(311 + 6);
    chk("R7", "ready count over two segments", readyCount, 864);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule